// File: doc/BRIEF.md
# Three-Channel Palette and Gamma Lookup Table

This block sits in a pixel pipeline and remaps each incoming pixel through three 256-entry by 8-bit tables, one per colour channel. In direct mode each colour component looks up its own table, which suits gamma or tone curves. In indexed mode a single 8-bit index, carried on the red lane, selects one entry in all three tables at once, giving a 256-colour palette. A bypass mode forwards pixels unchanged. Every mode has one cycle of latency, and the valid flag is delayed by the same amount.

The tables have two write sources. The first is a register write port with a 10-bit address: the top two bits pick the channel and the low eight bits pick the entry. The second is in-band loading from the pixel stream itself. When this is enabled, a 768-byte burst arriving on the red lane is captured in a window. The window opens at pixel 0 of the line two lines before the configured first active line. It closes at the middle of the line just before the first active line. The bytes come entry by entry, each entry as red, then green, then blue. A small state machine governs the capture, with the states LD_IDLE, LD_CAPTURE and LD_DONE, and these transitions:
- LD_IDLE to LD_CAPTURE on the window start.
- LD_CAPTURE to LD_DONE when the 768th byte is written, when the window closes, or when loading is disabled.
- LD_DONE to LD_IDLE once the line and pixel position are outside the window.

Top module: `palette_lut_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid_o` is 0 and all three output components are 0.
- R2: `out_valid_o` equals the value `pix_valid_i` had one clock earlier.
- R3: When `cfg_mode_i` is 2'b00 (bypass) or 2'b11 (treated as bypass), each output component equals the matching input component from one clock earlier.
- R4: When `cfg_mode_i` is 2'b01 (direct), one clock later `out_r_o` is red table[`pix_r_i`], `out_g_o` is green table[`pix_g_i`] and `out_b_o` is blue table[`pix_b_i`].
- R5: When `cfg_mode_i` is 2'b10 (indexed), `pix_r_i` is the index. One clock later the three outputs are entry [index] of the red, green and blue tables, and `pix_g_i` and `pix_b_i` have no effect.
- R6: A register write with `wr_en_i` high stores `wr_data_i` in the entry given by `wr_addr_i[7:0]`. `wr_addr_i[9:8]` selects the table: 0 is red, 1 is green and 2 is blue. Channel value 3 writes nothing.
- R7: With `cfg_inband_en_i` high, capture starts at pixel 0 of line `cfg_first_line_i`-2. Every cycle with `pix_valid_i` high inside the window takes the byte on `pix_r_i`. Byte k goes to entry k/3 of the red table when k mod 3 = 0, the green table when k mod 3 = 1, and the blue table when k mod 3 = 2.
- R8: The window closes at line `cfg_first_line_i`-1, pixel `cfg_line_len_i`/2. No byte at or after that point is captured, and entries not reached keep their previous contents.
- R9: Capture stops after exactly 768 bytes, even if the window is still open. Later bytes in the window change no table.
- R10: A register write in the same cycle as an in-band capture write is discarded.
- R11: With `cfg_inband_en_i` low, pixel data in the window writes no table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_r_i | input | 8 | Red component; palette index in indexed mode; load byte lane |
| pix_g_i | input | 8 | Green component |
| pix_b_i | input | 8 | Blue component |
| line_i | input | 11 | Current line number |
| pixel_i | input | 12 | Current pixel number within the line |
| cfg_first_line_i | input | 11 | Number of the first active line (at least 2) |
| cfg_line_len_i | input | 12 | Pixels per line, used for the mid-line window end |
| cfg_mode_i | input | 2 | 00 bypass, 01 direct, 10 indexed, 11 bypass |
| cfg_inband_en_i | input | 1 | Enables in-band table loading |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 10 | Register write address: [9:8] channel, [7:0] entry |
| wr_data_i | input | 8 | Register write data |
| out_valid_o | output | 1 | Output pixel valid |
| out_r_o | output | 8 | Output red |
| out_g_o | output | 8 | Output green |
| out_b_o | output | 8 | Output blue |

## Verification
The lookup is driven with three distinct table contents per channel. Direct-mode vectors therefore show whether each component addresses its own table. Indexed-mode vectors with differing green and blue lanes show whether all three tables follow the red-lane index. A first in-band load uses a long window, so capture must end on the byte count, and a register write collides with it partway through. A second load uses a short line, so capture must end at the mid-line boundary, and the entries past that point must hold the first load's values. A pass with loading disabled, and a write to channel 3, each check that a table stays unchanged.

// File: rtl/palette_lut_pkg.sv
package palette_lut_pkg;
    typedef enum logic [1:0] {
        MODE_BYPASS = 2'b00,
        MODE_DIRECT = 2'b01,
        MODE_INDEX  = 2'b10,
        MODE_RSVD   = 2'b11
    } lut_mode_e;

    typedef enum logic [1:0] {
        LD_IDLE    = 2'b00,
        LD_CAPTURE = 2'b01,
        LD_DONE    = 2'b10
    } ld_state_e;

    localparam int NUM_CH = 3;
endpackage

// File: rtl/lut_bank.sv
module lut_bank #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [DATA_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << DATA_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Registered read; a same-cycle write to the read entry returns old data.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
        rdata_o <= mem[raddr_i];
    end
endmodule

// File: rtl/inband_loader.sv
module inband_loader
    import palette_lut_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINE_W = 11,
    parameter int PIX_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [PIX_W-1:0]  pixel_i,
    input  logic [LINE_W-1:0] first_line_i,
    input  logic [PIX_W-1:0]  line_len_i,
    output logic              we_o,
    output logic [1:0]        ch_o,
    output logic [DATA_W-1:0] entry_o,
    output logic [DATA_W-1:0] data_o
);
    localparam logic [LINE_W-1:0] ONE_L = LINE_W'(1);
    localparam logic [LINE_W-1:0] TWO_L = LINE_W'(2);

    ld_state_e         state_q, state_d;
    logic [1:0]        chan_q;
    logic [DATA_W-1:0] entry_q;
    logic [LINE_W-1:0] first_m1, first_m2;
    logic              in_win, start, last_byte;

    assign first_m1  = first_line_i - ONE_L;
    assign first_m2  = first_line_i - TWO_L;
    assign in_win    = (line_i == first_m2) ||
                       ((line_i == first_m1) && (pixel_i < (line_len_i >> 1)));
    assign start     = en_i && (line_i == first_m2) && (pixel_i == '0);
    assign last_byte = (chan_q == 2'd2) && (entry_q == '1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE: begin
                if (start) state_d = LD_CAPTURE;
            end
            LD_CAPTURE: begin
                if (!in_win || !en_i)      state_d = LD_DONE;
                else if (we_o && last_byte) state_d = LD_DONE;
            end
            LD_DONE: begin
                if (!in_win) state_d = LD_IDLE;
            end
            default: state_d = LD_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        we_o    = 1'b0;
        ch_o    = chan_q;
        entry_o = entry_q;
        data_o  = byte_i;
        unique case (state_q)
            LD_IDLE:    we_o = start && valid_i;
            LD_CAPTURE: we_o = in_win && en_i && valid_i;
            LD_DONE:    we_o = 1'b0;
            default:    we_o = 1'b0;
        endcase
    end

    // Byte position: channel within entry, then entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q  <= 2'd0;
            entry_q <= '0;
        end else if ((state_q == LD_DONE) || ((state_q == LD_IDLE) && !start)) begin
            chan_q  <= 2'd0;
            entry_q <= '0;
        end else if (we_o) begin
            if (chan_q == 2'd2) begin
                chan_q  <= 2'd0;
                entry_q <= entry_q + 1'b1;
            end else begin
                chan_q  <= chan_q + 2'd1;
            end
        end
    end

    // R8: capture only ever happens on the two lines preceding the first active line
    a_r8_window_lines: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> ((line_i == first_m2) || (line_i == first_m1)));

    // R9: no further byte is taken in the cycle after the 768th
    a_r9_stop_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && last_byte) |=> !we_o);

    // R7: interleave position never reaches a fourth channel
    a_r7_channel_range: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> (ch_o != 2'd3));
endmodule

// File: rtl/palette_lut_top.sv
module palette_lut_top
    import palette_lut_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINE_W = 11,
    parameter int PIX_W  = 12,
    localparam int ADDR_W = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid_i,
    input  logic [DATA_W-1:0] pix_r_i,
    input  logic [DATA_W-1:0] pix_g_i,
    input  logic [DATA_W-1:0] pix_b_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [PIX_W-1:0]  pixel_i,
    input  logic [LINE_W-1:0] cfg_first_line_i,
    input  logic [PIX_W-1:0]  cfg_line_len_i,
    input  logic [1:0]        cfg_mode_i,
    input  logic              cfg_inband_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_r_o,
    output logic [DATA_W-1:0] out_g_o,
    output logic [DATA_W-1:0] out_b_o
);
    lut_mode_e         mode_in, mode_q;
    logic              valid_q;
    logic [DATA_W-1:0] pix_comp [NUM_CH];
    logic [DATA_W-1:0] byp_q    [NUM_CH];
    logic [DATA_W-1:0] ram_q    [NUM_CH];
    logic [DATA_W-1:0] out_comp [NUM_CH];

    logic              ld_we;
    logic [1:0]        ld_ch;
    logic [DATA_W-1:0] ld_entry, ld_data;

    assign mode_in     = lut_mode_e'(cfg_mode_i);
    assign pix_comp[0] = pix_r_i;
    assign pix_comp[1] = pix_g_i;
    assign pix_comp[2] = pix_b_i;

    inband_loader #(
        .DATA_W (DATA_W),
        .LINE_W (LINE_W),
        .PIX_W  (PIX_W)
    ) u_loader (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (cfg_inband_en_i),
        .valid_i      (pix_valid_i),
        .byte_i       (pix_r_i),
        .line_i       (line_i),
        .pixel_i      (pixel_i),
        .first_line_i (cfg_first_line_i),
        .line_len_i   (cfg_line_len_i),
        .we_o         (ld_we),
        .ch_o         (ld_ch),
        .entry_o      (ld_entry),
        .data_o       (ld_data)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
        logic              bank_we;
        logic [DATA_W-1:0] bank_wa, bank_wd, bank_ra;

        // Write source: in-band capture wins over the register port
        always_comb begin
            if (ld_we) begin
                bank_we = (ld_ch == 2'(c));
                bank_wa = ld_entry;
                bank_wd = ld_data;
            end else begin
                bank_we = wr_en_i && (wr_addr_i[ADDR_W-1:DATA_W] == 2'(c));
                bank_wa = wr_addr_i[DATA_W-1:0];
                bank_wd = wr_data_i;
            end
        end

        assign bank_ra = (mode_in == MODE_INDEX) ? pix_r_i : pix_comp[c];

        lut_bank #(
            .DATA_W (DATA_W)
        ) u_bank (
            .clk     (clk),
            .we_i    (bank_we),
            .waddr_i (bank_wa),
            .wdata_i (bank_wd),
            .raddr_i (bank_ra),
            .rdata_o (ram_q[c])
        );

        // R10: during a capture cycle only the captured byte may reach a table
        a_r10_inband_priority: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_we && wr_en_i && bank_we) |-> (bank_wd == pix_r_i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byp_q[c] <= '0;
            end else begin
                byp_q[c] <= pix_comp[c];
            end
        end

        assign out_comp[c] = ((mode_q == MODE_DIRECT) || (mode_q == MODE_INDEX))
                             ? ram_q[c] : byp_q[c];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_BYPASS;
            valid_q <= 1'b0;
        end else begin
            mode_q  <= mode_in;
            valid_q <= pix_valid_i;
        end
    end

    assign out_valid_o = valid_q;
    assign out_r_o     = out_comp[0];
    assign out_g_o     = out_comp[1];
    assign out_b_o     = out_comp[2];

    // R2: valid follows the input valid one clock later
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> out_valid_o);
    a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> !out_valid_o);

    // R3: bypass forwards the pixel unchanged after one clock
    a_r3_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode_i == 2'b00) |=>
        ((out_r_o == $past(pix_r_i)) && (out_g_o == $past(pix_g_i)) &&
         (out_b_o == $past(pix_b_i))));
endmodule

// File: tb/test_palette_lut_top.sv
module test_palette_lut_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_valid_i = 1'b0;
    logic [7:0] pix_r_i = '0, pix_g_i = '0, pix_b_i = '0;
    logic [10:0] line_i = '0;
    logic [11:0] pixel_i = '0;
    logic [10:0] cfg_first_line_i = 11'd10;
    logic [11:0] cfg_line_len_i = 12'd1000;
    logic [1:0] cfg_mode_i = 2'b00;
    logic       cfg_inband_en_i = 1'b1;
    logic       wr_en_i = 1'b0;
    logic [9:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       out_valid_o;
    logic [7:0] out_r_o, out_g_o, out_b_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] mr [256];
    logic [7:0] mg [256];
    logic [7:0] mb [256];

    always #5 clk = ~clk;

    palette_lut_top i_palette_lut_top (
        .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid_i),
        .pix_r_i(pix_r_i), .pix_g_i(pix_g_i), .pix_b_i(pix_b_i),
        .line_i(line_i), .pixel_i(pixel_i), .cfg_first_line_i(cfg_first_line_i),
        .cfg_line_len_i(cfg_line_len_i), .cfg_mode_i(cfg_mode_i),
        .cfg_inband_en_i(cfg_inband_en_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .out_valid_o(out_valid_o), .out_r_o(out_r_o),
        .out_g_o(out_g_o), .out_b_o(out_b_o)
    );

    // Stimulus vectors: {mode, r, g, b}
    localparam logic [25:0] VEC [10] = '{
        {2'b00, 8'h12, 8'h34, 8'h56},
        {2'b11, 8'hFF, 8'h00, 8'h80},
        {2'b01, 8'h00, 8'h00, 8'h00},
        {2'b01, 8'hFF, 8'h7F, 8'h80},
        {2'b01, 8'h10, 8'h20, 8'h30},
        {2'b10, 8'h00, 8'h99, 8'h42},
        {2'b10, 8'hFF, 8'h11, 8'h22},
        {2'b10, 8'h5A, 8'h00, 8'hFF},
        {2'b00, 8'hA5, 8'h5A, 8'hC3},
        {2'b10, 8'h80, 8'h80, 8'h80}
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] ch, input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = {ch, idx}; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // One pixel; outputs checked one clock later at the falling edge
    task automatic lookup(input logic [1:0] m, input logic [7:0] r, input logic [7:0] g,
                          input logic [7:0] b, output logic [7:0] qr,
                          output logic [7:0] qg, output logic [7:0] qb, output logic qv);
        @(negedge clk);
        cfg_mode_i = m; pix_r_i = r; pix_g_i = g; pix_b_i = b; pix_valid_i = 1'b1;
        @(negedge clk);
        qr = out_r_o; qg = out_g_o; qb = out_b_o; qv = out_valid_o;
        pix_valid_i = 1'b0;
    endtask

    task automatic stream_px(input logic [10:0] ln, input logic [11:0] px, input logic [7:0] d);
        @(negedge clk);
        line_i = ln; pixel_i = px; pix_r_i = d; pix_valid_i = 1'b1;
    endtask

    task automatic sweep(input string tag, input int lo, input int hi);
        logic [7:0] qr, qg, qb;
        logic qv;
        for (int i = lo; i <= hi; i++) begin
            lookup(2'b10, 8'(i), 8'h00, 8'h00, qr, qg, qb, qv);
            check(tag, qr, mr[i]);
            check(tag, qg, mg[i]);
            check(tag, qb, mb[i]);
        end
    endtask

    initial begin : watchdog
        #200us;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] qr, qg, qb, er, eg, eb;
        logic qv;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid in reset", {7'd0, out_valid_o}, 8'd0);
        check("R1 red in reset", out_r_o, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {7'd0, out_valid_o}, 8'd0);
        check("R1 blue after reset", out_b_o, 8'd0);

        // R6: preload every table through the register port
        for (int i = 0; i < 256; i++) begin
            reg_write(2'd0, 8'(i), 8'(i) ^ 8'h5A);  mr[i] = 8'(i) ^ 8'h5A;
            reg_write(2'd1, 8'(i), 8'(i + 3));      mg[i] = 8'(i + 3);
            reg_write(2'd2, 8'(i), ~8'(i));         mb[i] = ~8'(i);
        end
        // R6: channel 3 writes nothing
        reg_write(2'd3, 8'd0, 8'h99);

        // R3 R4 R5: vector table
        for (int v = 0; v < 10; v++) begin
            lookup(VEC[v][25:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], qr, qg, qb, qv);
            unique case (VEC[v][25:24])
                2'b01: begin er = mr[VEC[v][23:16]]; eg = mg[VEC[v][15:8]]; eb = mb[VEC[v][7:0]]; end
                2'b10: begin er = mr[VEC[v][23:16]]; eg = mg[VEC[v][23:16]]; eb = mb[VEC[v][23:16]]; end
                default: begin er = VEC[v][23:16]; eg = VEC[v][15:8]; eb = VEC[v][7:0]; end
            endcase
            check("R2 valid one clock later", {7'd0, qv}, 8'd1);
            check("R3 R4 R5 red", qr, er);
            check("R3 R4 R5 green", qg, eg);
            check("R3 R4 R5 blue", qb, eb);
        end
        @(negedge clk);
        check("R2 valid falls", {7'd0, out_valid_o}, 8'd0);
        sweep("R6 channel 3 ignored", 0, 0);

        // R7 R9 R10: long window, capture must stop at 768 bytes
        cfg_mode_i = 2'b00;
        for (int k = 0; k < 1000; k++) begin
            stream_px(11'd8, 12'(k), 8'(k * 5 + 1));
            wr_en_i = (k == 700);
            wr_addr_i = {2'd1, 8'd5}; wr_data_i = 8'hEE;
            if (k < 768) begin
                unique case (k % 3)
                    0: mr[k / 3] = 8'(k * 5 + 1);
                    1: mg[k / 3] = 8'(k * 5 + 1);
                    default: mb[k / 3] = 8'(k * 5 + 1);
                endcase
            end
        end
        @(negedge clk);
        wr_en_i = 1'b0; pix_valid_i = 1'b0; line_i = 11'd20; pixel_i = '0;
        @(negedge clk);
        line_i = 11'd0;
        sweep("R7 R9 in-band load", 0, 255);
        lookup(2'b10, 8'd5, 8'd0, 8'd0, qr, qg, qb, qv);
        check("R10 collided register write dropped", qg, 8'(16 * 5 + 1));

        // R8: short line, window ends at line 9 pixel 100
        cfg_line_len_i = 12'd200;
        for (int k = 0; k < 400; k++) begin
            stream_px(k < 200 ? 11'd8 : 11'd9, 12'(k % 200), 8'(k * 3 + 7));
            if (k < 300) begin
                unique case (k % 3)
                    0: mr[k / 3] = 8'(k * 3 + 7);
                    1: mg[k / 3] = 8'(k * 3 + 7);
                    default: mb[k / 3] = 8'(k * 3 + 7);
                endcase
            end
        end
        @(negedge clk);
        pix_valid_i = 1'b0; line_i = 11'd0; pixel_i = '0;
        sweep("R8 entries before window end", 0, 99);
        sweep("R8 entries after window end keep old", 100, 255);

        // R11: loading disabled, window data must not land
        cfg_inband_en_i = 1'b0;
        for (int k = 0; k < 12; k++) stream_px(11'd8, 12'(k), 8'hAA);
        @(negedge clk);
        pix_valid_i = 1'b0; line_i = 11'd0;
        sweep("R11 disabled load ignored", 0, 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule